// File: doc/BRIEF.md
# External Memory Bank Chip-Enable Decoder

This block sits between a processor's 24-bit external memory address and the port pins that reach the external memory chips. A small set of control fields chooses how large a bank each chip enable covers and how many chip enables are in service. From these fields the block decides, pin by pin, whether a port pin carries a memory function or stays general I/O. For each memory cycle it drives the active-low chip enable whose bank holds the address, and it drives the high address lines that the chosen bank size needs.

There are two families of enables. Eight program enables serve program-memory cycles and are split into a lower group of four and an upper group of four. Four peripheral enables serve data-memory cycles. Each family has its own bank size. A cycle-type input picks the family that decodes. The control fields are written through a simple address/data register port and read back combinationally. Their reset values depend on whether the internal ROM is enabled.

All memory-function outputs are registered. They follow the presented cycle by exactly one clock.

Top module: `ext_bank_decoder`

## Requirements
- R1: On synchronous reset, the fields take these values. The program size is 111 (4MB), or 101 (2MB) when `rom_en` is high. The lower count is 111. The upper count is 000, or 111 when `rom_en` is high. The peripheral size and the peripheral count are both 000.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the field that `cfg_addr` selects. Address 0 holds the program size in bits 2:0. Address 1 holds the lower count in bits 2:0 and the upper count in bits 6:4. Address 2 holds the peripheral size in bits 2:0. Address 3 holds the peripheral count in bits 2:0. `cfg_rdata` returns the same layout, with all other bits zero.
- R3: The program size code sets how many high address pins are memory functions. Codes 000 to 101 select 0, 1, 2, 3, 4 and 5 pins, starting at A16 (bit 0 of `hi_addr`). Codes 110 and 111 select all 6 pins. `hi_addr_sel` marks those pins. During a valid cycle, `hi_addr` carries `acc_addr[21:16]` on the selected pins and 0 on the others.
- R4: The program bank size is 2^S bytes. S is 15, 17, 18, 19, 20 and 21 for size codes 000 to 101, and 22 for 110 and 111. On a valid program cycle, enable k (`prog_ce_n[k]`) goes low when `acc_addr >> S` equals k and enable k is in service.
- R5: A count code with bit 2 set puts into service the first (code[1:0]+1) enables of its group. A count code with bit 2 clear (000 to 011) puts none into service. `prog_ce_sel[3:0]` shows the lower group in service.
- R6: The upper count field governs enables 4 to 7 in the same way, counting up from enable 4. `prog_ce_sel[7:4]` shows this group.
- R7: The peripheral bank size is 2^S bytes. S is 15, 17, 18, 19 and 20 for codes 000 to 100, and 20 for codes above 100. On a valid data cycle, `per_ce_n[k]` goes low when `acc_addr >> S` equals k and peripheral enable k is in service, under the coding of R5. `per_ce_sel` shows the peripheral enables in service.
- R8: Only program enables decode on a program cycle (`acc_data` low), and only peripheral enables decode on a data cycle (`acc_data` high).
- R9: An address whose bank index points at an enable that is not in service, or beyond the last enable, drives no enable low.
- R10: Outputs change one clock after the cycle is presented. When `acc_valid` is low, all enables read high one clock later and `hi_addr` reads 0.
- R11: At most one enable of a group is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_en | input | 1 | Internal ROM enabled; selects the reset defaults |
| cfg_we | input | 1 | Control field write strobe |
| cfg_addr | input | 2 | Control field address |
| cfg_wdata | input | 8 | Control write data |
| cfg_rdata | output | 8 | Control read data for `cfg_addr` |
| acc_valid | input | 1 | An external memory cycle is presented |
| acc_data | input | 1 | 1 = data-memory cycle, 0 = program-memory cycle |
| acc_addr | input | 24 | Cycle address |
| prog_ce_n | output | 8 | Active-low program chip enables |
| prog_ce_sel | output | 8 | 1 = program enable pin in memory function |
| per_ce_n | output | 4 | Active-low peripheral chip enables |
| per_ce_sel | output | 4 | 1 = peripheral enable pin in memory function |
| hi_addr | output | 6 | High address lines A16 to A21 |
| hi_addr_sel | output | 6 | 1 = high address pin in memory function |

## Verification
The hardest condition to reach is an address that lands on a legal bank index whose enable is out of service. The hardest form of it is an index that falls in the gap between the lower and upper program groups, or past the last peripheral enable. Reaching it needs both the bank size and the count fields rewritten at run time, then an address placed just over a bank boundary. The stimulus reprograms the fields through the register port. It then sweeps every program size code against addresses at each bank boundary in both cycle types, and a scoreboard predicts each result from the field values.

// File: rtl/ext_bank_pkg.sv
package ext_bank_pkg;

  localparam logic [1:0] FLD_PSIZE = 2'd0;
  localparam logic [1:0] FLD_PCNT  = 2'd1;
  localparam logic [1:0] FLD_DSIZE = 2'd2;
  localparam logic [1:0] FLD_DCNT  = 2'd3;

  typedef struct packed {
    logic [2:0] psize;
    logic [2:0] lo_cnt;
    logic [2:0] up_cnt;
    logic [2:0] dsize;
    logic [2:0] dcnt;
  } bank_cfg_t;

  // log2 of program bank bytes
  function automatic logic [4:0] prog_shift(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd15;
      3'd1:    return 5'd17;
      3'd2:    return 5'd18;
      3'd3:    return 5'd19;
      3'd4:    return 5'd20;
      3'd5:    return 5'd21;
      default: return 5'd22;
    endcase
  endfunction

  // log2 of peripheral bank bytes, saturating at 1MB
  function automatic logic [4:0] data_shift(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd15;
      3'd1:    return 5'd17;
      3'd2:    return 5'd18;
      3'd3:    return 5'd19;
      default: return 5'd20;
    endcase
  endfunction

  // number of high address pins in memory function
  function automatic int hi_pins(input logic [2:0] code);
    return (code >= 3'd6) ? 6 : int'(code);
  endfunction

endpackage

// File: rtl/ext_bank_cfg.sv
module ext_bank_cfg
  import ext_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rom_en,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output bank_cfg_t  cfg
);

  logic unused_bits;
  assign unused_bits = ^{wdata[7], wdata[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.psize  <= rom_en ? 3'b101 : 3'b111;
      cfg.lo_cnt <= 3'b111;
      cfg.up_cnt <= rom_en ? 3'b111 : 3'b000;
      cfg.dsize  <= 3'b000;
      cfg.dcnt   <= 3'b000;
    end else if (we) begin
      case (addr)
        FLD_PSIZE: cfg.psize <= wdata[2:0];
        FLD_PCNT: begin
          cfg.lo_cnt <= wdata[2:0];
          cfg.up_cnt <= wdata[6:4];
        end
        FLD_DSIZE: cfg.dsize <= wdata[2:0];
        default:   cfg.dcnt  <= wdata[2:0];
      endcase
    end
  end

  always_comb begin
    case (addr)
      FLD_PSIZE: rdata = {5'b0, cfg.psize};
      FLD_PCNT:  rdata = {1'b0, cfg.up_cnt, 1'b0, cfg.lo_cnt};
      FLD_DSIZE: rdata = {5'b0, cfg.dsize};
      default:   rdata = {5'b0, cfg.dcnt};
    endcase
  end

  // R2: a field write is visible on the next cycle
  p_wr_psize_r2: assert property (@(posedge clk) disable iff (rst)
    (we && addr == FLD_PSIZE) |=> (cfg.psize == $past(wdata[2:0])));
  p_wr_pcnt_r2: assert property (@(posedge clk) disable iff (rst)
    (we && addr == FLD_PCNT) |=> (cfg.up_cnt == $past(wdata[6:4])
                                  && cfg.lo_cnt == $past(wdata[2:0])));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cfg));

endmodule

// File: rtl/ext_bank_group.sv
module ext_bank_group #(
  parameter int ADDR_W = 24,
  parameter int N      = 4,
  parameter int BASE   = 0,
  localparam int CW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_en,
  input  logic [4:0]        shift,
  input  logic [CW:0]       cnt,
  input  logic [ADDR_W-1:0] addr,
  output logic [N-1:0]      ce_n,
  output logic [N-1:0]      sel
);

  logic [ADDR_W-1:0] idx;
  logic [N-1:0]      in_service;
  logic [N-1:0]      hit;

  assign idx = addr >> shift;

  for (genvar k = 0; k < N; k++) begin : g_lane
    localparam logic [CW-1:0] KV = CW'(k);
    assign in_service[k] = cnt[CW] && (KV <= cnt[CW-1:0]);
    assign hit[k] = hit_en && in_service[k] && (idx == ADDR_W'(BASE + k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n <= '1;
      sel  <= '0;
    end else begin
      ce_n <= ~hit;
      sel  <= in_service;
    end
  end

  // R11: never more than one enable low
  p_single_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ce_n));
  // R10: no cycle, no enable
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !hit_en |=> (&ce_n));
  // R9: a lane out of service never goes low
  p_service_r9: assert property (@(posedge clk) disable iff (rst)
    $stable(cnt) |=> ((~ce_n & ~sel) == '0));

endmodule

// File: rtl/ext_bank_hiaddr.sv
module ext_bank_hiaddr #(
  parameter int HI_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic [2:0]      code,
  input  logic [HI_W-1:0] addr_hi,
  output logic [HI_W-1:0] hi,
  output logic [HI_W-1:0] hi_sel
);
  import ext_bank_pkg::*;

  logic [HI_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < HI_W; i++) mask[i] = (i < hi_pins(code));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi     <= '0;
      hi_sel <= '0;
    end else begin
      hi     <= valid ? (addr_hi & mask) : '0;
      hi_sel <= mask;
    end
  end

  // R10: idle cycle leaves the high lines at zero
  p_hi_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (hi == '0));
  // R3: unselected pins never carry address
  p_hi_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (hi & ~hi_sel) == '0);

endmodule

// File: rtl/ext_bank_decoder.sv
module ext_bank_decoder
  import ext_bank_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int GRP_N  = 4,
  parameter int HI_W   = 6,
  parameter int HI_LSB = 16,
  localparam int CW    = $clog2(GRP_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rom_en,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              acc_valid,
  input  logic              acc_data,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [2*GRP_N-1:0] prog_ce_n,
  output logic [2*GRP_N-1:0] prog_ce_sel,
  output logic [GRP_N-1:0]  per_ce_n,
  output logic [GRP_N-1:0]  per_ce_sel,
  output logic [HI_W-1:0]   hi_addr,
  output logic [HI_W-1:0]   hi_addr_sel
);

  bank_cfg_t  cfg;
  logic       prog_cyc;
  logic       data_cyc;
  logic [4:0] p_shift;
  logic [4:0] d_shift;

  assign prog_cyc = acc_valid && !acc_data;
  assign data_cyc = acc_valid && acc_data;
  assign p_shift  = prog_shift(cfg.psize);
  assign d_shift  = data_shift(cfg.dsize);

  ext_bank_cfg u_cfg (
    .clk(clk), .rst(rst), .rom_en(rom_en),
    .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg)
  );

  ext_bank_group #(.ADDR_W(ADDR_W), .N(GRP_N), .BASE(0)) u_prog_lo (
    .clk(clk), .rst(rst), .hit_en(prog_cyc), .shift(p_shift),
    .cnt(cfg.lo_cnt[CW:0]), .addr(acc_addr),
    .ce_n(prog_ce_n[GRP_N-1:0]), .sel(prog_ce_sel[GRP_N-1:0])
  );

  ext_bank_group #(.ADDR_W(ADDR_W), .N(GRP_N), .BASE(GRP_N)) u_prog_up (
    .clk(clk), .rst(rst), .hit_en(prog_cyc), .shift(p_shift),
    .cnt(cfg.up_cnt[CW:0]), .addr(acc_addr),
    .ce_n(prog_ce_n[2*GRP_N-1:GRP_N]), .sel(prog_ce_sel[2*GRP_N-1:GRP_N])
  );

  ext_bank_group #(.ADDR_W(ADDR_W), .N(GRP_N), .BASE(0)) u_data (
    .clk(clk), .rst(rst), .hit_en(data_cyc), .shift(d_shift),
    .cnt(cfg.dcnt[CW:0]), .addr(acc_addr),
    .ce_n(per_ce_n), .sel(per_ce_sel)
  );

  ext_bank_hiaddr #(.HI_W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .valid(acc_valid), .code(cfg.psize),
    .addr_hi(acc_addr[HI_LSB +: HI_W]),
    .hi(hi_addr), .hi_sel(hi_addr_sel)
  );

  // R8: the two families never decode together
  p_family_r8: assert property (@(posedge clk) disable iff (rst)
    !((~&prog_ce_n) && (~&per_ce_n)));
  // R8: a data cycle leaves every program enable high
  p_data_only_r8: assert property (@(posedge clk) disable iff (rst)
    data_cyc |=> (&prog_ce_n));
  // R11: at most one program enable across both groups
  p_prog_one_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~prog_ce_n));

endmodule

// File: tb/ext_bank_decoder_test.sv
`timescale 1ns/1ps
module ext_bank_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rom_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [7:0]  cfg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_data = 1'b0;
  logic [23:0] acc_addr = 24'd0;
  logic [7:0]  prog_ce_n, prog_ce_sel;
  logic [3:0]  per_ce_n, per_ce_sel;
  logic [5:0]  hi_addr, hi_addr_sel;

  int errors = 0;
  int checks = 0;

  // mirror of the control fields
  logic [2:0] m_psize, m_lo, m_up, m_dsize, m_dcnt;

  typedef struct {
    logic [7:0] pce;
    logic [3:0] dce;
    logic [5:0] hi;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  ext_bank_decoder uut (
    .clk(clk), .rst(rst), .rom_en(rom_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_data(acc_data), .acc_addr(acc_addr),
    .prog_ce_n(prog_ce_n), .prog_ce_sel(prog_ce_sel),
    .per_ce_n(per_ce_n), .per_ce_sel(per_ce_sel),
    .hi_addr(hi_addr), .hi_addr_sel(hi_addr_sel)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int n_on(input logic [2:0] c);
    return c[2] ? int'(c[1:0]) + 1 : 0;
  endfunction

  function automatic logic [3:0] lanes(input logic [2:0] c);
    case (n_on(c))
      1: return 4'b0001;
      2: return 4'b0011;
      3: return 4'b0111;
      4: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [5:0] m_hisel(input logic [2:0] c);
    case (c)
      3'd0: return 6'h00;
      3'd1: return 6'h01;
      3'd2: return 6'h03;
      3'd3: return 6'h07;
      3'd4: return 6'h0F;
      3'd5: return 6'h1F;
      default: return 6'h3F;
    endcase
  endfunction

  function automatic logic [7:0] m_prog(input logic [23:0] a);
    int sh, idx;
    logic [7:0] r = 8'hFF;
    case (m_psize)
      3'd0: sh = 15; 3'd1: sh = 17; 3'd2: sh = 18; 3'd3: sh = 19;
      3'd4: sh = 20; 3'd5: sh = 21; default: sh = 22;
    endcase
    idx = int'(a >> sh);
    if (idx < n_on(m_lo)) r[idx] = 1'b0;
    else if (idx >= 4 && idx < 4 + n_on(m_up)) r[idx] = 1'b0;
    return r;
  endfunction

  function automatic logic [3:0] m_data(input logic [23:0] a);
    int sh, idx;
    logic [3:0] r = 4'hF;
    case (m_dsize)
      3'd0: sh = 15; 3'd1: sh = 17; 3'd2: sh = 18; 3'd3: sh = 19;
      default: sh = 20;
    endcase
    idx = int'(a >> sh);
    if (idx < n_on(m_dcnt)) r[idx] = 1'b0;
    return r;
  endfunction

  // driver: presents one cycle, queues its prediction
  task automatic issue(input logic v, input logic d, input logic [23:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = v; acc_data = d; acc_addr = a;
    e.pce = (v && !d) ? m_prog(a) : 8'hFF;
    e.dce = (v && d) ? m_data(a) : 4'hF;
    e.hi  = v ? (a[21:16] & m_hisel(m_psize)) : 6'h00;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares each queued item one clock later
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(prog_ce_n == e.pce, {e.tag, " prog_ce_n"}, int'(prog_ce_n), int'(e.pce));
      chk(per_ce_n == e.dce, {e.tag, " per_ce_n"}, int'(per_ce_n), int'(e.dce));
      chk(hi_addr == e.hi, {e.tag, " hi_addr"}, int'(hi_addr), int'(e.hi));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: m_psize = d[2:0];
      2'd1: begin m_lo = d[2:0]; m_up = d[6:4]; end
      2'd2: m_dsize = d[2:0];
      default: m_dcnt = d[2:0];
    endcase
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, tag, int'(cfg_rdata), int'(exp));
  endtask

  task automatic sel_chk(input string tag);
    @(negedge clk);
    chk(prog_ce_sel == {lanes(m_up), lanes(m_lo)}, {tag, " prog_ce_sel"},
        int'(prog_ce_sel), int'({lanes(m_up), lanes(m_lo)}));
    chk(per_ce_sel == lanes(m_dcnt), {tag, " per_ce_sel"}, int'(per_ce_sel), int'(lanes(m_dcnt)));
    chk(hi_addr_sel == m_hisel(m_psize), {tag, " hi_addr_sel"},
        int'(hi_addr_sel), int'(m_hisel(m_psize)));
  endtask

  task automatic do_reset(input logic rom);
    @(negedge clk);
    rst = 1'b1; rom_en = rom; acc_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_psize = rom ? 3'b101 : 3'b111;
    m_lo = 3'b111;
    m_up = rom ? 3'b111 : 3'b000;
    m_dsize = 3'b000;
    m_dcnt = 3'b000;
    chk(&prog_ce_n && &per_ce_n && hi_addr == 6'h00, "R1 outputs idle after reset",
        int'({prog_ce_n, per_ce_n}), 32'hFFF);
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 defaults with internal ROM disabled
    do_reset(1'b0);
    rd_chk(2'd0, 8'h07, "R1 size default rom off");
    rd_chk(2'd1, 8'h07, "R1 count default rom off");
    rd_chk(2'd2, 8'h00, "R1 data size default");
    rd_chk(2'd3, 8'h00, "R1 data count default");
    sel_chk("R1 R5 R3 defaults rom off");

    // R4 4MB banks, R10 idle afterwards
    issue(1'b1, 1'b0, 24'h000000, "R4 4MB idx0");
    issue(1'b1, 1'b0, 24'h400000, "R4 4MB idx1");
    issue(1'b1, 1'b0, 24'hC12345, "R4 4MB idx3");
    issue(1'b1, 1'b1, 24'h000000, "R8 data cycle no enables");
    issue(1'b0, 1'b0, 24'h400000, "R10 idle");

    // R1 defaults with internal ROM enabled, R6 upper group
    do_reset(1'b1);
    rd_chk(2'd0, 8'h05, "R1 size default rom on");
    rd_chk(2'd1, 8'h77, "R1 count default rom on");
    sel_chk("R1 R6 defaults rom on");
    issue(1'b1, 1'b0, 24'hE00000, "R6 2MB idx7");
    issue(1'b1, 1'b0, 24'h300000, "R3 R4 2MB idx1");
    issue(1'b1, 1'b0, 24'h9FFFFF, "R6 2MB idx4");
    issue(1'b0, 1'b0, 24'h000000, "R10 idle");

    // R2 write and readback, 32kB banks, R9 beyond enables
    wr(2'd0, 8'hF8);
    wr(2'd1, 8'h85);
    rd_chk(2'd0, 8'h00, "R2 size readback");
    rd_chk(2'd1, 8'h05, "R2 count readback");
    sel_chk("R2 R5 32kB two lanes");
    issue(1'b1, 1'b0, 24'h008000, "R4 32kB idx1");
    issue(1'b1, 1'b0, 24'h010000, "R9 32kB idx2 out of service");
    issue(1'b1, 1'b0, 24'h007FFF, "R4 32kB idx0");
    wr(2'd1, 8'h03);
    sel_chk("R5 code 011 none");
    issue(1'b1, 1'b0, 24'h000000, "R5 code 011 none");
    // R6 upper group alone, gap indices dead
    wr(2'd1, 8'h60);
    wr(2'd0, 8'h06);
    issue(1'b1, 1'b0, 24'h000000, "R9 lower group off");
    issue(1'b1, 1'b0, 24'h000000, "R10 settle");

    // R7 peripheral enables
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h06);
    rd_chk(2'd2, 8'h01, "R2 data size readback");
    rd_chk(2'd3, 8'h06, "R2 data count readback");
    sel_chk("R7 three peripheral lanes");
    issue(1'b1, 1'b1, 24'h040000, "R7 128kB idx2");
    issue(1'b1, 1'b1, 24'h060000, "R9 128kB idx3 out of service");
    issue(1'b1, 1'b0, 24'h040000, "R8 program cycle same address");
    issue(1'b1, 1'b1, 24'h01FFFF, "R7 128kB idx0");
    wr(2'd2, 8'h07);
    wr(2'd3, 8'h07);
    issue(1'b1, 1'b1, 24'h300000, "R7 size 111 as 1MB idx3");
    issue(1'b1, 1'b1, 24'h400000, "R9 1MB idx4 beyond");
    issue(1'b0, 1'b1, 24'h000000, "R10 idle");

    // sweep all program sizes and counts across bank boundaries
    for (int s = 0; s < 8; s++) begin
      wr(2'd0, 8'(s));
      wr(2'd1, 8'h76);
      sel_chk("R3 R5 R6 sweep");
      for (int b = 0; b < 10; b++) begin
        int sh;
        sh = (s == 0) ? 15 : (s >= 6 ? 22 : 16 + s);
        issue(1'b1, 1'b0, 24'(b << sh), "R4 R6 R11 sweep base");
        issue(1'b1, 1'b0, 24'((b << sh) + (1 << sh) - 1), "R4 R3 sweep top");
        issue(1'b1, 1'b1, 24'(b << sh), "R8 R7 sweep data");
      end
      issue(1'b0, 1'b0, 24'h0, "R10 sweep idle");
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule